// File: doc/BRIEF.md
# Extended-Precision Accumulator Add-with-Carry Unit

This datapath block keeps two 56-bit accumulators. Each is an 8-bit guard byte above a 48-bit long word. On a one-cycle operation strobe it takes one of two 48-bit source operands and widens it to 56 bits by copying its sign bit. It adds the widened operand and the incoming carry flag to the chosen accumulator and writes the sum back into that accumulator. In the same clock edge it produces a new status byte. That byte holds carry, overflow, zero, negative, unnormalized, extension-in-use and a sticky limit flag.

The surrounding core supplies the current status byte on `status_in` and takes the updated byte from `status_out`. Wide sums are built in steps. A first step runs with `op_plain` high, so no carry enters, and adds the low long words. A second step runs with `op_plain` low and adds the high long words plus the carry that the first step produced. A separate load port writes a 48-bit long word into either accumulator and fills the guard byte with its sign. This keeps the carry out of bit 55 correct for such chains.

Top module: `adc_long_unit`

## Requirements
- R1: After reset both accumulators read zero, `status_out` reads 0x00 and `op_done` is low.
- R2: On a clock edge where `op_valid` is high, the accumulator chosen by `op_dst_sel` (0 = A, 1 = B) takes the low 56 bits of accumulator + widened source + carry-in. An accumulator that is not written keeps its value.
- R3: The source chosen by `op_src_sel` (0 = `src_x`, 1 = `src_y`) is widened by copying its bit 47 into result bits 55..48 before the add.
- R4: The carry-in is `status_in` bit 0 when `op_plain` is low, and zero when `op_plain` is high.
- R5: Status bit 0 (C) is the carry out of bit 55 of the unsigned 56-bit add.
- R6: Status bit 3 (N) is result bit 55. Status bit 2 (Z) is set only when all 56 result bits are zero.
- R7: Status bit 1 (V) is set when the signed sum does not fit in 56 bits.
- R8: Status bit 6 (L) becomes `status_in` bit 6 OR V. The add never clears it.
- R9: Status bit 5 (E) is set when result bits 55..47 are not all equal. Status bit 4 (U) is set when result bit 47 equals bit 46.
- R10: Status bit 7 is copied from `status_in` bit 7 on an operation. With `op_valid` low, `status_out` holds its value.
- R11: A load (`ld_valid` high) writes `ld_word` into bits 47..0 of the accumulator chosen by `ld_sel` and copies bit 47 into bits 55..48.
- R12: If a load and an operation target the same accumulator in one cycle, the sum is stored and the load is dropped. If they target different accumulators, both writes take effect.
- R13: `op_done` is high for exactly the cycle after each cycle where `op_valid` was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | One-cycle strobe that starts an add |
| op_src_sel | input | 1 | Source select: 0 = src_x, 1 = src_y |
| op_dst_sel | input | 1 | Accumulator select: 0 = A, 1 = B |
| op_plain | input | 1 | Forces the carry-in to zero |
| src_x | input | 48 | First source operand |
| src_y | input | 48 | Second source operand |
| ld_valid | input | 1 | Long-word load strobe |
| ld_sel | input | 1 | Load target: 0 = A, 1 = B |
| ld_word | input | 48 | Long word to load |
| status_in | input | 8 | Current status byte (carry-in in bit 0, prior limit in bit 6) |
| status_out | output | 8 | Registered status byte: L E U N Z V C in bits 6..0 |
| acc_a | output | 56 | Accumulator A |
| acc_b | output | 56 | Accumulator B |
| op_done | output | 1 | High the cycle after an operation |

## Verification
The long-word load and the add both write the accumulator bank, and they can be asked for in the same cycle. The bench provokes this twice. In the first case both requests name accumulator A, and the bench expects the sum in A with the load lost. In the second case the add names A while the load names B, and the bench expects the sum in A and the sign-widened word in B. A long run of adds of the largest positive long word pushes an accumulator through its guard byte into signed overflow. That run checks the moment V first rises, L stays set afterwards, and E and U track the value at every step.

// File: rtl/adc_pkg.sv
package adc_pkg;

  localparam int WORD_W = 48;
  localparam int EXT_W  = 8;
  localparam int ACC_W  = WORD_W + EXT_W;

  // Status byte bit positions (the surrounding core decodes them)
  localparam int ST_C   = 0;
  localparam int ST_V   = 1;
  localparam int ST_Z   = 2;
  localparam int ST_N   = 3;
  localparam int ST_U   = 4;
  localparam int ST_E   = 5;
  localparam int ST_L   = 6;
  localparam int ST_RSV = 7;

  // Packed so that l lands on bit 6 and c on bit 0
  typedef struct packed {
    logic l;
    logic e;
    logic u;
    logic n;
    logic z;
    logic v;
    logic c;
  } adc_flags_t;

  // Widen a long word by replicating its sign into the guard byte
  function automatic logic [ACC_W-1:0] widen_word(input logic [WORD_W-1:0] w);
    return {{EXT_W{w[WORD_W-1]}}, w};
  endfunction

  // True when every bit of the slice agrees
  function automatic logic all_same(input logic [EXT_W:0] bits);
    return (bits == '0) || (&bits);
  endfunction

endpackage

// File: rtl/adc_operand_prep.sv
module adc_operand_prep #(
  parameter int WORD_W  = adc_pkg::WORD_W,
  parameter int EXT_W   = adc_pkg::EXT_W,
  parameter int NUM_SRC = 2,
  parameter int SEL_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic [WORD_W-1:0]       src_bank [NUM_SRC],
  input  logic [SEL_W-1:0]        sel,
  output logic [WORD_W+EXT_W-1:0] operand,
  output logic                    src_sign
);

  logic [WORD_W-1:0] picked;

  assign picked   = src_bank[sel];
  assign src_sign = picked[WORD_W-1];
  assign operand[WORD_W-1:0] = picked;

  // R3: guard byte of the operand is the source sign
  for (genvar g = 0; g < EXT_W; g++) begin : g_ext
    assign operand[WORD_W+g] = src_sign;
  end

endmodule

// File: rtl/adc_carry_adder.sv
module adc_carry_adder #(
  parameter int ACC_W = adc_pkg::ACC_W
) (
  input  logic [ACC_W-1:0] a,
  input  logic [ACC_W-1:0] b,
  input  logic             cin,
  output logic [ACC_W-1:0] sum,
  output logic             cout
);

  logic [ACC_W:0] full;

  assign full = {1'b0, a} + {1'b0, b} + {{ACC_W{1'b0}}, cin};
  assign sum  = full[ACC_W-1:0];
  assign cout = full[ACC_W];

endmodule

// File: rtl/adc_flag_gen.sv
module adc_flag_gen
  import adc_pkg::*;
#(
  parameter int WORD_W = adc_pkg::WORD_W,
  parameter int ACC_W  = adc_pkg::ACC_W
) (
  input  logic [ACC_W-1:0] dst_val,
  input  logic [ACC_W-1:0] src_val,
  input  logic [ACC_W-1:0] res,
  input  logic             carry,
  input  logic             limit_in,
  output adc_flags_t       flags
);

  logic ovf;

  // R7: like-signed inputs giving an unlike-signed result
  assign ovf = (src_val[ACC_W-1] == dst_val[ACC_W-1]) &&
               (res[ACC_W-1] != dst_val[ACC_W-1]);

  always_comb begin
    flags.c = carry;                               // R5
    flags.v = ovf;                                 // R7
    flags.z = (res == '0);                         // R6
    flags.n = res[ACC_W-1];                        // R6
    flags.u = (res[WORD_W-1] == res[WORD_W-2]);    // R9
    flags.e = !all_same(res[ACC_W-1:WORD_W-1]);    // R9
    flags.l = limit_in | ovf;                      // R8
  end

  // R6: a zero result cannot be negative
  always_comb begin
    p_zero_not_neg_r6: assert (!(flags.z && flags.n));
  end

endmodule

// File: rtl/adc_acc_bank.sv
module adc_acc_bank
  import adc_pkg::*;
#(
  parameter int WORD_W  = adc_pkg::WORD_W,
  parameter int EXT_W   = adc_pkg::EXT_W,
  parameter int NUM_ACC = 2,
  parameter int SEL_W   = (NUM_ACC > 1) ? $clog2(NUM_ACC) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    add_we,
  input  logic [SEL_W-1:0]        add_sel,
  input  logic [WORD_W+EXT_W-1:0] add_data,
  input  logic                    ld_we,
  input  logic [SEL_W-1:0]        ld_sel,
  input  logic [WORD_W-1:0]       ld_word,
  output logic [WORD_W+EXT_W-1:0] acc_q [NUM_ACC]
);

  localparam int AW = WORD_W + EXT_W;

  logic [NUM_ACC-1:0] add_hit;
  logic [NUM_ACC-1:0] ld_hit;

  for (genvar i = 0; i < NUM_ACC; i++) begin : g_acc
    // R12: an add to the same accumulator takes priority over a load
    assign add_hit[i] = add_we && (add_sel == SEL_W'(i));
    assign ld_hit[i]  = ld_we && (ld_sel == SEL_W'(i)) && !add_hit[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        acc_q[i] <= '0;                                            // R1
      end else if (add_hit[i]) begin
        acc_q[i] <= add_data;                                      // R2
      end else if (ld_hit[i]) begin
        acc_q[i] <= {{EXT_W{ld_word[WORD_W-1]}}, ld_word};         // R11
      end
    end

    // R2: untouched accumulators keep their value
    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !((add_we && add_sel == SEL_W'(i)) || (ld_we && ld_sel == SEL_W'(i)))
      |=> $stable(acc_q[i]));

    // R11: a load that wins leaves a sign-consistent guard byte
    p_load_widen_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_we && ld_sel == SEL_W'(i) && !(add_we && add_sel == SEL_W'(i)))
      |=> (all_same(acc_q[i][AW-1:WORD_W-1]) &&
           acc_q[i][WORD_W-1:0] == $past(ld_word)));

    // R12: the add result is what lands on a collision
    p_add_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (add_we && add_sel == SEL_W'(i)) |=> (acc_q[i] == $past(add_data)));
  end

endmodule

// File: rtl/adc_long_unit.sv
module adc_long_unit
  import adc_pkg::*;
#(
  parameter int WORD_W = adc_pkg::WORD_W,
  parameter int EXT_W  = adc_pkg::EXT_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    op_valid,
  input  logic                    op_src_sel,
  input  logic                    op_dst_sel,
  input  logic                    op_plain,
  input  logic [WORD_W-1:0]       src_x,
  input  logic [WORD_W-1:0]       src_y,
  input  logic                    ld_valid,
  input  logic                    ld_sel,
  input  logic [WORD_W-1:0]       ld_word,
  input  logic [7:0]              status_in,
  output logic [7:0]              status_out,
  output logic [WORD_W+EXT_W-1:0] acc_a,
  output logic [WORD_W+EXT_W-1:0] acc_b,
  output logic                    op_done
);

  localparam int AW      = WORD_W + EXT_W;
  localparam int NUM_ACC = 2;
  localparam int NUM_SRC = 2;

  logic [WORD_W-1:0] src_bank [NUM_SRC];
  logic [AW-1:0]     acc_q    [NUM_ACC];
  logic [AW-1:0]     operand;
  logic              src_sign;
  logic [AW-1:0]     dst_val;
  logic [AW-1:0]     sum;
  logic              carry_in;
  logic              carry_out;
  adc_flags_t        flags;
  logic              ovf_evt;

  assign src_bank[0] = src_x;
  assign src_bank[1] = src_y;

  adc_operand_prep #(.WORD_W(WORD_W), .EXT_W(EXT_W), .NUM_SRC(NUM_SRC), .SEL_W(1)) u_prep (
    .src_bank (src_bank),
    .sel      (op_src_sel),
    .operand  (operand),
    .src_sign (src_sign)
  );

  assign dst_val  = acc_q[op_dst_sel];
  assign carry_in = status_in[ST_C] & ~op_plain;    // R4

  adc_carry_adder #(.ACC_W(AW)) u_add (
    .a    (dst_val),
    .b    (operand),
    .cin  (carry_in),
    .sum  (sum),
    .cout (carry_out)
  );

  adc_flag_gen #(.WORD_W(WORD_W), .ACC_W(AW)) u_flags (
    .dst_val  (dst_val),
    .src_val  (operand),
    .res      (sum),
    .carry    (carry_out),
    .limit_in (status_in[ST_L]),
    .flags    (flags)
  );

  assign ovf_evt = flags.v;

  adc_acc_bank #(.WORD_W(WORD_W), .EXT_W(EXT_W), .NUM_ACC(NUM_ACC), .SEL_W(1)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .add_we   (op_valid),
    .add_sel  (op_dst_sel),
    .add_data (sum),
    .ld_we    (ld_valid),
    .ld_sel   (ld_sel),
    .ld_word  (ld_word),
    .acc_q    (acc_q)
  );

  assign acc_a = acc_q[0];
  assign acc_b = acc_q[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_out <= '0;                               // R1
      op_done    <= 1'b0;
    end else begin
      op_done <= op_valid;                            // R13
      if (op_valid) begin
        status_out <= {status_in[ST_RSV], flags};     // R10
      end
    end
  end

  // R13: completion strobe follows the request by one cycle
  p_done_follows_r13: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> op_done);
  p_done_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> !op_done);

  // R10: status holds between operations
  p_status_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> $stable(status_out));

  // R8: an incoming limit flag survives the add
  p_limit_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && status_in[ST_L]) |=> status_out[ST_L]);

  // R8: an overflow event always raises limit
  p_ovf_sets_limit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && ovf_evt) |=> (status_out[ST_L] && status_out[ST_V]));

  // R3: the widened operand sign agrees with the selected source
  p_operand_sign_r3: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |-> (operand[AW-1] == (op_src_sel ? src_y[WORD_W-1] : src_x[WORD_W-1])));

endmodule

// File: tb/adc_long_unit_tb.sv
`timescale 1ns/1ps
module adc_long_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic        op_src_sel = 1'b0;
  logic        op_dst_sel = 1'b0;
  logic        op_plain = 1'b0;
  logic [47:0] src_x = '0;
  logic [47:0] src_y = '0;
  logic        ld_valid = 1'b0;
  logic        ld_sel = 1'b0;
  logic [47:0] ld_word = '0;
  logic [7:0]  status_in = '0;
  logic [7:0]  status_out;
  logic [55:0] acc_a;
  logic [55:0] acc_b;
  logic        op_done;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [55:0] mdl_acc [2];

  always #2 clk = ~clk;

  adc_long_unit dut_i (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_src_sel(op_src_sel),
    .op_dst_sel(op_dst_sel), .op_plain(op_plain), .src_x(src_x), .src_y(src_y),
    .ld_valid(ld_valid), .ld_sel(ld_sel), .ld_word(ld_word),
    .status_in(status_in), .status_out(status_out),
    .acc_a(acc_a), .acc_b(acc_b), .op_done(op_done)
  );

  // Vector: {load word, source, dst, src sel, plain, carry in, limit in, bit7}
  localparam int NVEC = 8;
  localparam logic [101:0] VEC [NVEC] = '{
    {48'h000000000001, 48'h000000000001, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
    {48'h800000000000, 48'h800000000000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
    {48'hFFFFFFFFFFFF, 48'h000000000001, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    {48'h7FFFFFFFFFFF, 48'h7FFFFFFFFFFF, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
    {48'h123456789ABC, 48'hFEDCBA987654, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1},
    {48'h400000000000, 48'h000000000000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    {48'h000000000000, 48'h000000000000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    {48'h00000000FFFF, 48'hFFFFFFFF0000, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0}
  };

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Reference: signed arithmetic in 64 bits, overflow as loss of value on truncation
  task automatic ref_add(input logic [55:0] d, input logic [47:0] s, input logic cin,
                         input logic [7:0] st, output logic [55:0] r, output logic [7:0] so);
    longint dv, sv, tot, rv;
    logic [63:0] ut;
    logic v, c, e, u;
    dv  = longint'($signed(d));
    sv  = longint'($signed(s));
    tot = dv + sv + longint'(cin);
    r   = tot[55:0];
    rv  = longint'($signed(r));
    v   = (tot != rv);
    ut  = {8'h00, d} + {8'h00, sv[55:0]} + 64'(cin);
    c   = ut[56];
    e   = (rv != longint'($signed(r[47:0])));
    u   = (r[47:46] == 2'b00) || (r[47:46] == 2'b11);
    so  = {st[7], st[6] | v, e, u, r[55], (r == 56'd0), v, c};
  endtask

  task automatic do_load(input logic sel, input logic [47:0] w);
    @(negedge clk);
    ld_valid = 1'b1; ld_sel = sel; ld_word = w;
    @(negedge clk);
    ld_valid = 1'b0;
    mdl_acc[sel] = {{8{w[47]}}, w};
  endtask

  // Issue one add, optionally with a load in the same cycle; compare at the next falling edge
  task automatic do_op(input logic dst, input logic ssel, input logic plain,
                       input logic [7:0] st, input logic with_ld, input logic lsel,
                       input logic [47:0] lw, input string tag);
    logic [55:0] r;
    logic [7:0]  so;
    logic [47:0] s;
    @(negedge clk);
    s = ssel ? src_y : src_x;
    ref_add(mdl_acc[dst], s, st[0] & ~plain, st, r, so);
    op_valid = 1'b1; op_dst_sel = dst; op_src_sel = ssel; op_plain = plain; status_in = st;
    ld_valid = with_ld; ld_sel = lsel; ld_word = lw;
    if (with_ld && lsel != dst) mdl_acc[lsel] = {{8{lw[47]}}, lw};
    mdl_acc[dst] = r;
    @(negedge clk);
    op_valid = 1'b0; ld_valid = 1'b0;
    check(acc_a == mdl_acc[0], {tag, " acc_a"}, 64'(acc_a), 64'(mdl_acc[0]));
    check(acc_b == mdl_acc[1], {tag, " acc_b"}, 64'(acc_b), 64'(mdl_acc[1]));
    check(status_out == so, {tag, " status"}, 64'(status_out), 64'(so));
    check(op_done == 1'b1, "R13 done pulse", 64'(op_done), 64'd1);
  endtask

  initial begin
    mdl_acc[0] = '0; mdl_acc[1] = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(acc_a == '0, "R1 acc_a reset", 64'(acc_a), 64'd0);
    check(acc_b == '0, "R1 acc_b reset", 64'(acc_b), 64'd0);
    check(status_out == 8'h00, "R1 status reset", 64'(status_out), 64'd0);
    check(op_done == 1'b0, "R1 done reset", 64'(op_done), 64'd0);
    rst_n = 1'b1;

    // R11: long-word load widens with the sign
    do_load(1'b0, 48'h900000000001);
    check(acc_a == 56'hFF900000000001, "R11 load negative", 64'(acc_a), 64'h00FF900000000001);
    do_load(1'b1, 48'h400000000000);
    check(acc_b == 56'h00400000000000, "R11 load positive", 64'(acc_b), 64'h0000400000000000);

    // Table walk: R2 R3 R4 R5 R6 R7 R8 R9 R10
    for (int k = 0; k < NVEC; k++) begin
      logic [101:0] v;
      v = VEC[k];
      src_x = v[53:6];
      src_y = v[53:6];
      do_load(v[5], v[101:54]);
      do_op(v[5], v[4], v[3], {v[0], v[1], 5'b0, v[2]}, 1'b0, 1'b0, '0, "R2/R9 table");
    end

    // Hand-worked low-then-high chain: R5 carry out, R4 carry in, R9 E/U
    src_x = 48'h800000000000; src_y = 48'h000000000001;
    do_load(1'b0, 48'h800000000000);
    do_load(1'b1, 48'h000000000001);
    do_op(1'b0, 1'b0, 1'b1, 8'h01, 1'b0, 1'b0, '0, "R5 low step");
    check(acc_a == 56'hFF000000000000, "R5 low sum", 64'(acc_a), 64'h00FF000000000000);
    check(status_out == 8'h39, "R5 low flags", 64'(status_out), 64'h39);
    do_op(1'b1, 1'b1, 1'b0, status_out, 1'b0, 1'b0, '0, "R4 high step");
    check(acc_b == 56'd3, "R4 high sum with carry", 64'(acc_b), 64'd3);
    check(status_out == 8'h10, "R4 high flags", 64'(status_out), 64'h10);

    // R4: plain add ignores a set carry flag
    do_load(1'b0, 48'h000000000005);
    do_op(1'b0, 1'b1, 1'b1, 8'h01, 1'b0, 1'b0, '0, "R4 plain");
    check(acc_a == 56'd6, "R4 plain sum", 64'(acc_a), 64'd6);

    // R10: status holds while idle, whatever status_in does
    @(negedge clk);
    status_in = 8'hFF;
    @(negedge clk);
    @(negedge clk);
    check(status_out == 8'h10, "R10 hold", 64'(status_out), 64'h10);
    check(op_done == 1'b0, "R13 idle", 64'(op_done), 64'd0);

    // R12: collision on the same accumulator, then on different ones
    src_x = 48'h000000000010;
    do_op(1'b0, 1'b0, 1'b1, 8'h00, 1'b1, 1'b0, 48'hABCDEF000000, "R12 same target");
    check(acc_a == 56'h16, "R12 add wins", 64'(acc_a), 64'h16);
    do_op(1'b0, 1'b0, 1'b1, 8'h00, 1'b1, 1'b1, 48'hABCDEF000000, "R12 split target");
    check(acc_b == 56'hFFABCDEF000000, "R12 load lands", 64'(acc_b), 64'h00FFABCDEF000000);

    // R7 R8 R9: ramp accumulator B up through the guard byte into overflow
    begin
      bit saw_v;
      bit saw_l_after;
      saw_v = 0; saw_l_after = 1;
      src_x = 48'h7FFFFFFFFFFF;
      do_load(1'b1, 48'h7FFFFFFFFFFF);
      for (int n = 0; n < 300; n++) begin
        do_op(1'b1, 1'b0, 1'b1, {1'b0, status_out[6], 6'b0}, 1'b0, 1'b0, '0, "R7 ramp");
        if (status_out[1]) saw_v = 1;
        if (saw_v && !status_out[6]) saw_l_after = 0;
      end
      check(saw_v, "R7 overflow reached", 64'(saw_v), 64'd1);
      check(saw_l_after, "R8 limit stays set", 64'(saw_l_after), 64'd1);
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule